// File: doc/BRIEF.md
# Per-Requester DMA Page Translation Checker

This block checks and translates DMA requests from I/O devices before they reach physical memory. Every request carries the identifier of the device that issued it, a device-virtual address and a read/write flag. The block looks up the pair (source identifier, virtual page number) in a small fully associative table. Each table entry maps one 4 KB page to a physical page and carries its own read and write permission bits. A request is granted and translated only when an entry for exactly that source and page exists and that entry permits the access type. Every other request is denied.

Because the source identifier is part of the lookup key, software can open a page to one requester while keeping it invisible to all the others. Removing the entry withdraws that access at once. A management port adds, overwrites and removes entries. Each lookup result appears one clock after its request. A lookup and a table change issued in the same clock are ordered so that the lookup sees the table as it was before the change.

Top module: `dma_page_guard`

## Requirements
- R1: A granted response carries a physical address made of the entry's physical page number in the upper bits and the request's low 12 address bits, passed through unchanged.
- R2: Lookup matches on both the source identifier and the virtual page number (address bits 31:12). A request from a different source for a page that is mapped only for another source is denied.
- R3: A matched request is granted only if the entry's read bit is set (for req_write=0) or its write bit is set (for req_write=1). Otherwise the request is denied.
- R4: A request with no matching entry is denied, and every denied response drives rsp_paddr to zero.
- R5: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and low otherwise. rsp_grant is never high without rsp_valid.
- R6: An add command (mgmt_op=0) for a (source, page) pair that is already present overwrites that entry's physical page and permissions without using another entry, and reports no error.
- R7: When all 16 entries hold distinct pairs, an add command for a new pair sets mgmt_err and leaves the table unchanged. An add that overwrites an existing pair still succeeds.
- R8: A remove command (mgmt_op=1) revokes access for that source and page only; entries of other sources stay in force. A remove for a pair that is absent sets mgmt_err.
- R9: A lookup in the same cycle as a table command sees the contents from before the command.
- R10: After synchronous reset the table is empty and rsp_valid, rsp_grant, rsp_paddr, mgmt_done and mgmt_err are zero.
- R11: mgmt_done is high exactly in the cycle after a cycle with mgmt_valid high. mgmt_err is only ever high together with mgmt_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | SRC_W | Requesting device identifier |
| req_vaddr | input | VA_W | Device-virtual target address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Result for the previous cycle's request |
| rsp_grant | output | 1 | 1 = access allowed, 0 = denied |
| rsp_paddr | output | PA_W | Translated physical address, zero when denied |
| mgmt_valid | input | 1 | Table command present this cycle |
| mgmt_op | input | 1 | 0 = add or overwrite, 1 = remove |
| mgmt_src | input | SRC_W | Source identifier of the entry |
| mgmt_vpn | input | VA_W-12 | Virtual page number of the entry |
| mgmt_ppn | input | PA_W-12 | Physical page number (add only) |
| mgmt_rd_ok | input | 1 | Read permission (add only) |
| mgmt_wr_ok | input | 1 | Write permission (add only) |
| mgmt_done | output | 1 | Command completed, one cycle after mgmt_valid |
| mgmt_err | output | 1 | Command rejected: table full or entry absent |

## Verification
The bench targets the isolation between sources. It maps one page for two sources with different permissions and checks that each source sees only its own rights. A design that matched on the page number alone would grant a stranger's request or apply the wrong permission bits. The bench also issues a remove and a lookup for the same pair in the same cycle. A design that forwarded the update would deny that lookup instead of granting it, and a design that left the entry in place would keep granting on the next cycle. The bench fills the table to its last slot and then tries an add for a new pair and an add for an existing pair. A wrong design would drop an entry silently, refuse a legal overwrite, or place a duplicate that makes later lookups ambiguous. A randomized phase over a small key space then compares every cycle with a queue-based model.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam int PAGE_BITS = 12;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_DEL = 1'b1
  } mgmt_op_e;
endpackage

// File: rtl/dpg_entry_store.sv
module dpg_entry_store #(
  parameter int N     = 16,
  parameter int SRC_W = 4,
  parameter int VPN_W = 20,
  parameter int PPN_W = 24,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] lk_src,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [SRC_W-1:0] mg_src,
  input  logic [VPN_W-1:0] mg_vpn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_rd,
  input  logic             wr_wr,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     lk_hit,
  output logic [N-1:0]     mg_hit,
  output logic [N-1:0]     valid_vec,
  output logic [PPN_W-1:0] ppn_arr [N],
  output logic [N-1:0]     rd_vec,
  output logic [N-1:0]     wr_vec
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic             vld_q;
    logic [SRC_W-1:0] src_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             rd_q;
    logic             wr_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        vld_q <= 1'b1;
      end else if (clr_en && clr_idx == IDX_W'(g)) begin
        vld_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        src_q <= mg_src;
        vpn_q <= mg_vpn;
        ppn_q <= wr_ppn;
        rd_q  <= wr_rd;
        wr_q  <= wr_wr;
      end
    end

    assign lk_hit[g]    = vld_q && src_q == lk_src && vpn_q == lk_vpn;
    assign mg_hit[g]    = vld_q && src_q == mg_src && vpn_q == mg_vpn;
    assign valid_vec[g] = vld_q;
    assign ppn_arr[g]   = ppn_q;
    assign rd_vec[g]    = rd_q;
    assign wr_vec[g]    = wr_q;
  end
endmodule

// File: rtl/dpg_slot_pick.sv
module dpg_slot_pick #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     key_hit,
  output logic             key_found,
  output logic [IDX_W-1:0] key_idx,
  output logic             free_found,
  output logic [IDX_W-1:0] free_idx
);
  always_comb begin
    key_found  = 1'b0;
    key_idx    = '0;
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (key_hit[i]) begin
        key_found = 1'b1;
        key_idx   = IDX_W'(i);
      end
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dpg_hit_mux.sv
module dpg_hit_mux #(
  parameter int N     = 16,
  parameter int PPN_W = 24
) (
  input  logic [N-1:0]     hit,
  input  logic [PPN_W-1:0] ppn_arr [N],
  input  logic [N-1:0]     rd_vec,
  input  logic [N-1:0]     wr_vec,
  input  logic             is_write,
  output logic             allow,
  output logic [PPN_W-1:0] ppn
);
  always_comb begin
    allow = 1'b0;
    ppn   = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) begin
        ppn   = ppn | ppn_arr[i];
        allow = allow | (is_write ? wr_vec[i] : rd_vec[i]);
      end
    end
  end
endmodule

// File: rtl/dma_page_guard.sv
module dma_page_guard #(
  parameter int N     = 16,
  parameter int SRC_W = 4,
  parameter int VA_W  = 32,
  parameter int PA_W  = 36,
  localparam int OFF_W = dpg_pkg::PAGE_BITS,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SRC_W-1:0] req_src,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic             rsp_grant,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             mgmt_valid,
  input  logic             mgmt_op,
  input  logic [SRC_W-1:0] mgmt_src,
  input  logic [VPN_W-1:0] mgmt_vpn,
  input  logic [PPN_W-1:0] mgmt_ppn,
  input  logic             mgmt_rd_ok,
  input  logic             mgmt_wr_ok,
  output logic             mgmt_done,
  output logic             mgmt_err
);
  import dpg_pkg::*;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     lk_hit, mg_hit, valid_vec, rd_vec, wr_vec;
  logic [PPN_W-1:0] ppn_arr [N];
  logic             key_found, free_found;
  logic [IDX_W-1:0] key_idx, free_idx, wr_idx;
  logic             do_add, do_del, wr_en, clr_en, add_fail;
  logic             lk_allow;
  logic [PPN_W-1:0] lk_ppn;

  assign do_add   = mgmt_valid && mgmt_op_e'(mgmt_op) == OP_ADD;
  assign do_del   = mgmt_valid && mgmt_op_e'(mgmt_op) == OP_DEL;
  assign wr_en    = do_add && (key_found || free_found);
  assign wr_idx   = key_found ? key_idx : free_idx;
  assign clr_en   = do_del && key_found;
  assign add_fail = do_add && !key_found && !free_found;

  dpg_entry_store #(.N(N), .SRC_W(SRC_W), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .lk_src   (req_src),
    .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
    .mg_src   (mgmt_src),
    .mg_vpn   (mgmt_vpn),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_ppn   (mgmt_ppn),
    .wr_rd    (mgmt_rd_ok),
    .wr_wr    (mgmt_wr_ok),
    .clr_en   (clr_en),
    .clr_idx  (key_idx),
    .lk_hit   (lk_hit),
    .mg_hit   (mg_hit),
    .valid_vec(valid_vec),
    .ppn_arr  (ppn_arr),
    .rd_vec   (rd_vec),
    .wr_vec   (wr_vec)
  );

  dpg_slot_pick #(.N(N)) u_pick (
    .valid_vec (valid_vec),
    .key_hit   (mg_hit),
    .key_found (key_found),
    .key_idx   (key_idx),
    .free_found(free_found),
    .free_idx  (free_idx)
  );

  dpg_hit_mux #(.N(N), .PPN_W(PPN_W)) u_mux (
    .hit     (lk_hit),
    .ppn_arr (ppn_arr),
    .rd_vec  (rd_vec),
    .wr_vec  (wr_vec),
    .is_write(req_write),
    .allow   (lk_allow),
    .ppn     (lk_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_paddr <= '0;
      mgmt_done <= 1'b0;
      mgmt_err  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && lk_allow;
      rsp_paddr <= (req_valid && lk_allow) ? {lk_ppn, req_vaddr[OFF_W-1:0]} : '0;
      mgmt_done <= mgmt_valid;
      mgmt_err  <= add_fail || (do_del && !key_found);
    end
  end
endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
  parameter int N     = 16,
  parameter int VA_W  = 32,
  parameter int PA_W  = 36
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic            rsp_grant,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            mgmt_valid,
  input logic            mgmt_done,
  input logic            mgmt_err,
  input logic [N-1:0]    lk_hit,
  input logic [N-1:0]    mg_hit
);
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_grant -> rsp_paddr[11:0] == $past(req_vaddr[11:0])));

  a_r4_deny_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_grant) |-> rsp_paddr == '0);

  a_r5_rsp_on_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r5_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r5_grant_in_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_grant |-> rsp_valid);

  a_r6_unique_lookup: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit));

  a_r6_unique_key: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mg_hit));

  a_r11_done_follows: assert property (@(posedge clk) disable iff (rst)
    mgmt_valid |=> mgmt_done);

  a_r11_err_with_done: assert property (@(posedge clk) disable iff (rst)
    mgmt_err |-> mgmt_done);
endmodule

bind dma_page_guard dpg_checker #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_dpg_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_grant (rsp_grant),
  .rsp_paddr (rsp_paddr),
  .mgmt_valid(mgmt_valid),
  .mgmt_done (mgmt_done),
  .mgmt_err  (mgmt_err),
  .lk_hit    (lk_hit),
  .mg_hit    (mg_hit)
);

// File: tb/test_dma_page_guard.sv
module test_dma_page_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_src = '0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_grant;
  logic [35:0] rsp_paddr;
  logic        mgmt_valid = 1'b0;
  logic        mgmt_op = 1'b0;
  logic [3:0]  mgmt_src = '0;
  logic [19:0] mgmt_vpn = '0;
  logic [23:0] mgmt_ppn = '0;
  logic        mgmt_rd_ok = 1'b0;
  logic        mgmt_wr_ok = 1'b0;
  logic        mgmt_done, mgmt_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_page_guard i_dma_page_guard (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_src(req_src), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_paddr(rsp_paddr),
    .mgmt_valid(mgmt_valid), .mgmt_op(mgmt_op), .mgmt_src(mgmt_src), .mgmt_vpn(mgmt_vpn),
    .mgmt_ppn(mgmt_ppn), .mgmt_rd_ok(mgmt_rd_ok), .mgmt_wr_ok(mgmt_wr_ok),
    .mgmt_done(mgmt_done), .mgmt_err(mgmt_err)
  );

  typedef struct {
    logic [3:0]  s;
    logic [19:0] v;
    logic [23:0] p;
    bit          r;
    bit          w;
  } ref_ent_t;
  ref_ent_t tbl[$];

  function automatic int ref_find(logic [3:0] s, logic [19:0] v);
    foreach (tbl[k]) if (tbl[k].s == s && tbl[k].v == v) return k;
    return -1;
  endfunction

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit rv, logic [3:0] s, logic [31:0] va, bit w,
                      bit mv, bit op, logic [3:0] ms, logic [19:0] mvpn,
                      logic [23:0] mppn, bit mr, bit mw, string tag);
    bit          e_grant, e_err;
    logic [35:0] e_pa;
    int          li, mi;
    @(negedge clk);
    req_valid = rv; req_src = s; req_vaddr = va; req_write = w;
    mgmt_valid = mv; mgmt_op = op; mgmt_src = ms; mgmt_vpn = mvpn;
    mgmt_ppn = mppn; mgmt_rd_ok = mr; mgmt_wr_ok = mw;
    li = ref_find(s, va[31:12]);
    e_grant = rv && li >= 0 && (w ? tbl[li].w : tbl[li].r);
    e_pa = e_grant ? {tbl[li].p, va[11:0]} : 36'h0;
    mi = ref_find(ms, mvpn);
    e_err = 1'b0;
    if (mv) begin
      if (op == 1'b0) begin
        if (mi >= 0) begin
          tbl[mi].p = mppn; tbl[mi].r = mr; tbl[mi].w = mw;
        end else if (tbl.size() < 16) begin
          tbl.push_back('{s: ms, v: mvpn, p: mppn, r: mr, w: mw});
        end else e_err = 1'b1;
      end else begin
        if (mi >= 0) tbl.delete(mi);
        else e_err = 1'b1;
      end
    end
    @(posedge clk);
    #1;
    check(tag, 40'(rsp_valid), 40'(rv), "rsp_valid");
    check(tag, 40'(rsp_grant), 40'(e_grant), "rsp_grant");
    check(tag, 40'(rsp_paddr), 40'(e_pa), "rsp_paddr");
    check(tag, 40'(mgmt_done), 40'(mv), "mgmt_done");
    check(tag, 40'(mgmt_err), 40'(e_err), "mgmt_err");
  endtask

  task automatic rd(logic [3:0] s, logic [31:0] va, bit w, string tag);
    step(1, s, va, w, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic add(logic [3:0] s, logic [19:0] v, logic [23:0] p, bit r, bit w, string tag);
    step(0, 0, 0, 0, 1, 0, s, v, p, r, w, tag);
  endtask

  task automatic del(logic [3:0] s, logic [19:0] v, string tag);
    step(0, 0, 0, 0, 1, 1, s, v, 0, 0, 0, tag);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R10", 40'(rsp_valid), 0, "rsp_valid in reset");
    check("R10", 40'(rsp_grant), 0, "rsp_grant in reset");
    check("R10", 40'(rsp_paddr), 0, "rsp_paddr in reset");
    check("R10", 40'(mgmt_done | mgmt_err), 0, "mgmt flags in reset");
    @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    rd(4'h1, 32'h12345_678, 0, "R10");
    rd(4'h1, 32'h00000_000, 1, "R4");

    add(4'h1, 20'h12345, 24'hABCDE0, 1, 0, "R11");
    rd(4'h1, 32'h12345_9F3, 0, "R1");
    rd(4'h1, 32'h12345_001, 1, "R3");
    rd(4'h2, 32'h12345_9F3, 0, "R2");
    add(4'h2, 20'h12345, 24'h000777, 0, 1, "R2");
    rd(4'h2, 32'h12345_ABC, 1, "R2");
    rd(4'h2, 32'h12345_ABC, 0, "R3");
    rd(4'h1, 32'h12345_ABC, 0, "R2");

    add(4'h1, 20'h12345, 24'h55AA55, 0, 1, "R6");
    rd(4'h1, 32'h12345_010, 1, "R6");
    rd(4'h1, 32'h12345_010, 0, "R6");

    step(1, 4'h1, 32'h12345_444, 1, 1, 1, 4'h1, 20'h12345, 0, 0, 0, "R9");
    rd(4'h1, 32'h12345_444, 1, "R8");
    rd(4'h2, 32'h12345_444, 1, "R8");
    del(4'h1, 20'h12345, "R8");

    step(1, 4'h3, 32'h00042_0F0, 0, 1, 0, 4'h3, 20'h00042, 24'h000042, 1, 1, "R9");
    rd(4'h3, 32'h00042_0F0, 0, "R9");

    for (int k = 0; k < 18; k++) add(4'h7, 20'(k + 100), 24'(k + 500), 1, 0, "R7");
    rd(4'h7, 32'((100 + 15) << 12), 0, "R7");
    add(4'h3, 20'h00042, 24'h0BEEF0, 1, 0, "R7");
    rd(4'h3, 32'h00042_123, 0, "R7");
    del(4'h7, 20'd100, "R8");
    add(4'h9, 20'h00001, 24'h000123, 1, 1, "R7");
    rd(4'h9, 32'h00001_FFF, 1, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    tbl.delete();
    rd(4'h9, 32'h00001_FFF, 1, "R10");

    for (int n = 0; n < 500; n++) begin
      automatic logic [3:0]  s  = 4'($urandom_range(0, 3));
      automatic logic [19:0] v  = 20'($urandom_range(0, 3));
      automatic logic [3:0]  ms = 4'($urandom_range(0, 3));
      automatic logic [19:0] mv = 20'($urandom_range(0, 3));
      step(bit'($urandom_range(0, 1)), s, {v, 12'($urandom)}, bit'($urandom_range(0, 1)),
           $urandom_range(0, 9) < 4, bit'($urandom_range(0, 2) == 0), ms, mv,
           24'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "R3");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule